// File: doc/BRIEF.md
# Instruction Parcel Sequencer with Extension Decode

The sequencer takes 60-bit instruction words from a fetch path and issues the instructions packed inside them, one per clock cycle. Each word is split into four 15-bit parcels. Parcel 0 is the most significant parcel. An instruction occupies one parcel (15 bits), two parcels (30 bits) or the whole word (60 bits). Each issued slot gives the instruction text left-aligned in a 60-bit field with the unused low bits cleared, the slot length in parcels, the parcel position where the slot starts, and a flag that marks the slot as illegal.

Parcels that begin with the octal digits 46 are reserved. Their meaning depends on two configuration inputs:
- When the extension unit is present, a reserved parcel with a nonzero third digit at parcel 0 takes the whole word as one extension instruction.
- When the extension unit is absent, such a parcel is a harmless no-op and decoding continues in the same word.
- Strict mode makes every reserved parcel other than the canonical no-op fault.

When a word is used up, the sequencer asks for the next word and waits for a valid handshake. A flush input drops whatever remains of the held word.

Top module: `parcel_sequencer`

## Requirements
- R1: Parcel k of a held word is word bits [59-15k -: 15]. Slots are issued one per cycle in rising parcel order. `issue_pos` gives the start parcel, and each next slot starts at the previous position plus the previous length.
- R2: A parcel is a 30-bit instruction (length 2) when its top two octal digits are 0 then 1..7, or 5..7 then 0..2. Any other non-reserved parcel has length 1. `issue_text` holds the slot's parcels left-aligned, with all bits below the slot cleared.
- R3: A 30-bit opcode found at parcel 3 is issued as a one-parcel slot with `issue_illegal` high, and the word ends there.
- R4: `fetch_req` is high exactly when no word is held and `flush` is low. A word is taken when `word_valid` and `fetch_req` are both high, and its first slot (position 0) is issued in the next cycle. The cycle after a slot that reaches the end of the word has `issue_valid` low and `fetch_req` high, and this state lasts until a word is supplied.
- R5: The parcel octal 46000 is a legal one-parcel no-op in every mode.
- R6: With `ext_present` high, a parcel at position 0 that matches octal 46yxx with y nonzero is issued as one legal 4-parcel slot. Its text is the whole word, and the following parcels are not issued separately.
- R7: With `ext_present` high, a 46yxx parcel with y nonzero at position 1, 2 or 3 is a one-parcel slot with `issue_illegal` high.
- R8: With `ext_present` and `strict_mode` low, every parcel with top digits 46 is a legal one-parcel no-op, and issue continues with the next parcel of the same word.
- R9: With `strict_mode` high, a parcel with top digits 46 that is neither 46000 nor an extension instruction under R6/R7 is a one-parcel slot with `issue_illegal` high.
- R10: In a cycle with `flush` high, `issue_valid` and `fetch_req` are low. The rest of the held word is dropped, and the next word taken starts issuing at parcel 0.
- R11: After reset no word is held: `fetch_req` is high and `issue_valid` and `issue_illegal` are low. `issue_illegal` is never high without `issue_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drop the held word and restart at the next word |
| ext_present | input | 1 | Extension unit is fitted |
| strict_mode | input | 1 | Only the canonical no-op is legal among reserved parcels |
| word_valid | input | 1 | A fetched word is offered |
| word_data | input | 60 | Offered instruction word, parcel 0 in bits 59:45 |
| fetch_req | output | 1 | Ready for a new word |
| issue_valid | output | 1 | A slot is issued this cycle |
| issue_text | output | 60 | Slot text, left-aligned, low bits zero |
| issue_len | output | 3 | Slot length in parcels (1, 2 or 4) |
| issue_pos | output | 2 | Parcel where the slot starts |
| issue_illegal | output | 1 | Issued slot is illegal |

## Verification
The words used each separate one decode question:
- A word of four short opcodes checks parcel order and alignment.
- A word of two 30-bit opcodes checks the length table and text masking.
- A word with a 30-bit opcode in its last parcel checks the straddle fault.

The same reserved parcels (46100, 46200, 46017, 46000) are then placed at different positions under each combination of extension presence and strict mode. This shows that the word-consuming, continuing-no-op and faulting interpretations are chosen by mode and position, not by the opcode alone. Flush in the middle of a word, and stalls with no word offered, check that issue stops and restarts at parcel 0.

// File: rtl/parcel_seq_pkg.sv
package parcel_seq_pkg;

    // Top two octal digits shared by the reserved encodings
    localparam logic [5:0] HEAD_RESERVED = 6'o46;

    typedef enum logic [1:0] {
        SZ_ONE,
        SZ_TWO,
        SZ_WORD
    } slot_size_e;

    typedef struct packed {
        slot_size_e size;
        logic       illegal;
    } slot_decode_t;

    // 30-bit formats: 01..07 and 50..52, 60..62, 70..72 (octal head)
    function automatic logic head_is_long(input logic [5:0] head);
        logic [2:0] d1;
        logic [2:0] d2;
        d1 = head[5:3];
        d2 = head[2:0];
        return ((d1 == 3'd0) && (d2 != 3'd0)) ||
               ((d1 >= 3'd5) && (d2 <= 3'd2));
    endfunction

endpackage

// File: rtl/ips_word_buffer.sv
module ips_word_buffer #(
    parameter int PARCEL_W = 15,
    parameter int PARCELS  = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                flush,
    input  logic                                load,
    input  logic [PARCEL_W*PARCELS-1:0]         word_in,
    input  logic [$clog2(PARCELS+1)-1:0]        step,
    output logic [PARCEL_W*PARCELS-1:0]         word_q,
    output logic [$clog2(PARCELS)-1:0]          pos_q,
    output logic                                full_q
);
    localparam int WORD_W = PARCEL_W * PARCELS;
    localparam int POS_W  = $clog2(PARCELS);
    localparam int CNT_W  = $clog2(PARCELS + 1);

    logic [CNT_W-1:0] next_sum;
    assign next_sum = CNT_W'(pos_q) + step;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            pos_q  <= '0;
            full_q <= 1'b0;
        end else if (flush) begin
            pos_q  <= '0;
            full_q <= 1'b0;
        end else if (load) begin
            word_q <= word_in;
            pos_q  <= '0;
            full_q <= 1'b1;
        end else if (full_q) begin
            if (next_sum >= CNT_W'(PARCELS)) begin
                pos_q  <= '0;
                full_q <= 1'b0;
            end else begin
                pos_q  <= next_sum[POS_W-1:0];
            end
        end
    end

    logic [WORD_W-1:0] unused_width_guard;
    assign unused_width_guard = '0;
endmodule

// File: rtl/ips_parcel_window.sv
module ips_parcel_window #(
    parameter int PARCEL_W = 15,
    parameter int PARCELS  = 4
) (
    input  logic [PARCEL_W*PARCELS-1:0] word_q,
    input  logic [$clog2(PARCELS)-1:0]  pos,
    output logic [PARCEL_W*PARCELS-1:0] shifted,
    output logic [PARCEL_W-1:0]         head_parcel
);
    localparam int WORD_W = PARCEL_W * PARCELS;

    assign shifted     = word_q << (int'(pos) * PARCEL_W);
    assign head_parcel = shifted[WORD_W-1 -: PARCEL_W];
endmodule

// File: rtl/ips_parcel_decoder.sv
module ips_parcel_decoder
    import parcel_seq_pkg::*;
#(
    parameter int PARCEL_W = 15,
    parameter int PARCELS  = 4
) (
    input  logic [PARCEL_W-1:0]         parcel,
    input  logic [$clog2(PARCELS)-1:0]  pos,
    input  logic                        ext_present,
    input  logic                        strict_mode,
    output slot_decode_t                dec
);
    localparam int POS_W = $clog2(PARCELS);

    logic [5:0] head;
    logic [2:0] ext_digit;
    logic       tail_zero;
    logic       reserved;
    logic       at_first;
    logic       at_last;

    assign head      = parcel[PARCEL_W-1 -: 6];
    assign ext_digit = parcel[PARCEL_W-7 -: 3];
    assign tail_zero = (parcel[PARCEL_W-7:0] == '0);
    assign reserved  = (head == HEAD_RESERVED);
    assign at_first  = (pos == '0);
    assign at_last   = (pos == POS_W'(PARCELS - 1));

    always_comb begin
        dec.size    = SZ_ONE;
        dec.illegal = 1'b0;
        if (reserved) begin
            if (tail_zero) begin
                dec.illegal = 1'b0;              // canonical no-op
            end else if (ext_present && (ext_digit != 3'd0)) begin
                if (at_first) begin
                    dec.size = SZ_WORD;          // extension takes the word
                end else begin
                    dec.illegal = 1'b1;          // extension must start at parcel 0
                end
            end else begin
                dec.illegal = strict_mode;       // non-canonical no-op
            end
        end else if (head_is_long(head)) begin
            if (at_last) begin
                dec.illegal = 1'b1;              // would straddle: pad to next word
            end else begin
                dec.size = SZ_TWO;
            end
        end
    end
endmodule

// File: rtl/ips_text_mask.sv
module ips_text_mask #(
    parameter int PARCEL_W = 15,
    parameter int PARCELS  = 4
) (
    input  logic [PARCEL_W*PARCELS-1:0]  shifted,
    input  logic [$clog2(PARCELS+1)-1:0] nparcels,
    input  logic                         enable,
    output logic [PARCEL_W*PARCELS-1:0]  text
);
    localparam int WORD_W = PARCEL_W * PARCELS;
    localparam int CNT_W  = $clog2(PARCELS + 1);

    for (genvar k = 0; k < PARCELS; k++) begin : g_mask
        assign text[WORD_W-1-k*PARCEL_W -: PARCEL_W] =
            (enable && (CNT_W'(k) < nparcels)) ? shifted[WORD_W-1-k*PARCEL_W -: PARCEL_W]
                                              : '0;
    end
endmodule

// File: rtl/parcel_sequencer.sv
module parcel_sequencer
    import parcel_seq_pkg::*;
#(
    parameter int PARCEL_W = 15,
    parameter int PARCELS  = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                flush,
    input  logic                                ext_present,
    input  logic                                strict_mode,
    input  logic                                word_valid,
    input  logic [PARCEL_W*PARCELS-1:0]         word_data,
    output logic                                fetch_req,
    output logic                                issue_valid,
    output logic [PARCEL_W*PARCELS-1:0]         issue_text,
    output logic [$clog2(PARCELS+1)-1:0]        issue_len,
    output logic [$clog2(PARCELS)-1:0]          issue_pos,
    output logic                                issue_illegal
);
    localparam int WORD_W = PARCEL_W * PARCELS;
    localparam int POS_W  = $clog2(PARCELS);
    localparam int CNT_W  = $clog2(PARCELS + 1);

    logic [WORD_W-1:0]   word_q;
    logic [POS_W-1:0]    pos_q;
    logic                full_q;
    logic [WORD_W-1:0]   shifted;
    logic [PARCEL_W-1:0] head_parcel;
    slot_decode_t        dec;
    logic [CNT_W-1:0]    nparcels;
    logic                load;

    assign fetch_req   = !full_q && !flush;
    assign issue_valid = full_q && !flush;
    assign load        = word_valid && fetch_req;

    always_comb begin
        case (dec.size)
            SZ_ONE:  nparcels = CNT_W'(1);
            SZ_TWO:  nparcels = CNT_W'(2);
            default: nparcels = CNT_W'(PARCELS);
        endcase
    end

    ips_word_buffer #(.PARCEL_W(PARCEL_W), .PARCELS(PARCELS)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .load    (load),
        .word_in (word_data),
        .step    (nparcels),
        .word_q  (word_q),
        .pos_q   (pos_q),
        .full_q  (full_q)
    );

    ips_parcel_window #(.PARCEL_W(PARCEL_W), .PARCELS(PARCELS)) u_win (
        .word_q      (word_q),
        .pos         (pos_q),
        .shifted     (shifted),
        .head_parcel (head_parcel)
    );

    ips_parcel_decoder #(.PARCEL_W(PARCEL_W), .PARCELS(PARCELS)) u_dec (
        .parcel      (head_parcel),
        .pos         (pos_q),
        .ext_present (ext_present),
        .strict_mode (strict_mode),
        .dec         (dec)
    );

    ips_text_mask #(.PARCEL_W(PARCEL_W), .PARCELS(PARCELS)) u_mask (
        .shifted  (shifted),
        .nparcels (nparcels),
        .enable   (issue_valid),
        .text     (issue_text)
    );

    assign issue_len     = issue_valid ? nparcels : '0;
    assign issue_pos     = issue_valid ? pos_q : '0;
    assign issue_illegal = issue_valid && dec.illegal;
endmodule

// File: rtl/parcel_sequencer_checker.sv
module parcel_sequencer_checker #(
    parameter int PARCEL_W = 15,
    parameter int PARCELS  = 4
) (
    input logic                                clk,
    input logic                                rst,
    input logic                                flush,
    input logic                                word_valid,
    input logic                                fetch_req,
    input logic                                issue_valid,
    input logic [PARCEL_W*PARCELS-1:0]         issue_text,
    input logic [$clog2(PARCELS+1)-1:0]        issue_len,
    input logic [$clog2(PARCELS)-1:0]          issue_pos,
    input logic                                issue_illegal
);
    localparam int WORD_W = PARCEL_W * PARCELS;
    localparam logic [PARCEL_W-1:0] NOP_CODE = PARCEL_W'(6'o46) << (PARCEL_W - 6);

    // R4: ready and issuing never overlap
    assert_ready_xor_issue_R4: assert property (@(posedge clk) disable iff (rst)
        !(fetch_req && issue_valid));

    // R4: a taken word issues from parcel 0 next cycle
    assert_load_starts_at_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && word_valid) |=> (flush || (issue_valid && issue_pos == '0)));

    // R1: next slot starts where the current one ends
    assert_pos_advance_R1: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && (int'(issue_pos) + int'(issue_len) < PARCELS)) |=>
        (flush || (issue_valid && int'(issue_pos) == $past(int'(issue_pos) + int'(issue_len)))));

    // R4: a slot that reaches the word end is followed by a gap
    assert_word_end_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && (int'(issue_pos) + int'(issue_len) >= PARCELS)) |=> !issue_valid);

    // R3: nothing longer than one parcel starts at the last parcel
    assert_last_parcel_short_R3: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && int'(issue_pos) == PARCELS - 1) |-> (issue_len == 1));

    // R6: full-word slots only at parcel 0 and legal
    assert_word_slot_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && int'(issue_len) == PARCELS) |-> (issue_pos == '0 && !issue_illegal));

    // R5: canonical no-op is always legal and one parcel
    assert_canonical_nop_R5: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_text[WORD_W-1 -: PARCEL_W] == NOP_CODE) |->
        (!issue_illegal && issue_len == 1));

    // R10: flush blocks issue and fetch, and nothing issues next cycle
    assert_flush_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        flush |-> (!issue_valid && !fetch_req));
    assert_flush_drops_word_R10: assert property (@(posedge clk) disable iff (rst)
        flush |=> !issue_valid);

    // R11: illegal only qualifies an issued slot
    assert_illegal_needs_issue_R11: assert property (@(posedge clk) disable iff (rst)
        issue_illegal |-> issue_valid);
endmodule

bind parcel_sequencer parcel_sequencer_checker #(.PARCEL_W(PARCEL_W), .PARCELS(PARCELS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .flush         (flush),
    .word_valid    (word_valid),
    .fetch_req     (fetch_req),
    .issue_valid   (issue_valid),
    .issue_text    (issue_text),
    .issue_len     (issue_len),
    .issue_pos     (issue_pos),
    .issue_illegal (issue_illegal)
);

// File: tb/parcel_sequencer_test.sv
`timescale 1ns/1ps
module parcel_sequencer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        ext_present = 1'b0;
    logic        strict_mode = 1'b0;
    logic        word_valid = 1'b0;
    logic [59:0] word_data = '0;
    logic        fetch_req;
    logic        issue_valid;
    logic [59:0] issue_text;
    logic [2:0]  issue_len;
    logic [1:0]  issue_pos;
    logic        issue_illegal;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    parcel_sequencer uut (
        .clk(clk), .rst(rst), .flush(flush), .ext_present(ext_present),
        .strict_mode(strict_mode), .word_valid(word_valid), .word_data(word_data),
        .fetch_req(fetch_req), .issue_valid(issue_valid), .issue_text(issue_text),
        .issue_len(issue_len), .issue_pos(issue_pos), .issue_illegal(issue_illegal)
    );

    function automatic logic [59:0] pack4(input logic [14:0] a, b, c, d);
        return {a, b, c, d};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // At a negedge: offer a word, wait one edge, leave first slot visible
    task automatic load_word(input string req, input logic [59:0] w);
        #1 chk(req, "fetch_req before load", 64'(fetch_req), 64'd1);
        word_valid = 1'b1;
        word_data  = w;
        @(negedge clk);
        word_valid = 1'b0;
        word_data  = '0;
    endtask

    task automatic expect_slot(input string req, input int pos, input int len,
                               input logic [59:0] text, input logic ill);
        #1;
        chk(req, "issue_valid", 64'(issue_valid), 64'd1);
        chk(req, "issue_pos", 64'(issue_pos), 64'(pos));
        chk(req, "issue_len", 64'(issue_len), 64'(len));
        chk(req, "issue_text", 64'(issue_text), 64'(text));
        chk(req, "issue_illegal", 64'(issue_illegal), 64'(ill));
        @(negedge clk);
    endtask

    task automatic expect_idle(input string req);
        #1;
        chk(req, "idle issue_valid", 64'(issue_valid), 64'd0);
        chk(req, "idle fetch_req", 64'(fetch_req), 64'd1);
        chk(req, "idle issue_illegal", 64'(issue_illegal), 64'd0);
        @(negedge clk);
    endtask

    task automatic test_reset;
        expect_idle("R11");
    endtask

    task automatic test_short_words;
        ext_present = 1'b0; strict_mode = 1'b0;
        load_word("R1", pack4(15'o10123, 15'o36777, 15'o43000, 15'o00017));
        expect_slot("R1", 0, 1, pack4(15'o10123, 0, 0, 0), 1'b0);
        expect_slot("R1", 1, 1, pack4(15'o36777, 0, 0, 0), 1'b0);
        expect_slot("R2", 2, 1, pack4(15'o43000, 0, 0, 0), 1'b0);
        expect_slot("R2", 3, 1, pack4(15'o00017, 0, 0, 0), 1'b0);
        expect_idle("R4");
    endtask

    task automatic test_long_words;
        load_word("R2", pack4(15'o02345, 15'o12345, 15'o51000, 15'o77777));
        expect_slot("R2", 0, 2, pack4(15'o02345, 15'o12345, 0, 0), 1'b0);
        expect_slot("R2", 2, 2, pack4(15'o51000, 15'o77777, 0, 0), 1'b0);
        // 53 is not in the long table: short
        load_word("R2", pack4(15'o53001, 15'o72000, 15'o11111, 15'o20000));
        expect_slot("R2", 0, 1, pack4(15'o53001, 0, 0, 0), 1'b0);
        expect_slot("R2", 1, 2, pack4(15'o72000, 15'o11111, 0, 0), 1'b0);
        expect_slot("R2", 3, 1, pack4(15'o20000, 0, 0, 0), 1'b0);
        expect_idle("R4");
    endtask

    task automatic test_straddle;
        load_word("R3", pack4(15'o10000, 15'o20000, 15'o30000, 15'o02345));
        expect_slot("R3", 0, 1, pack4(15'o10000, 0, 0, 0), 1'b0);
        expect_slot("R3", 1, 1, pack4(15'o20000, 0, 0, 0), 1'b0);
        expect_slot("R3", 2, 1, pack4(15'o30000, 0, 0, 0), 1'b0);
        expect_slot("R3", 3, 1, pack4(15'o02345, 0, 0, 0), 1'b1);
        expect_idle("R3");
    endtask

    task automatic test_extension;
        ext_present = 1'b1; strict_mode = 1'b0;
        load_word("R6", pack4(15'o46100, 15'o11111, 15'o22222, 15'o33333));
        expect_slot("R6", 0, 4, pack4(15'o46100, 15'o11111, 15'o22222, 15'o33333), 1'b0);
        expect_idle("R6");
        load_word("R7", pack4(15'o10000, 15'o46200, 15'o46000, 15'o10001));
        expect_slot("R7", 0, 1, pack4(15'o10000, 0, 0, 0), 1'b0);
        expect_slot("R7", 1, 1, pack4(15'o46200, 0, 0, 0), 1'b1);
        expect_slot("R5", 2, 1, pack4(15'o46000, 0, 0, 0), 1'b0);
        expect_slot("R7", 3, 1, pack4(15'o10001, 0, 0, 0), 1'b0);
        expect_idle("R7");
    endtask

    task automatic test_no_extension;
        ext_present = 1'b0; strict_mode = 1'b0;
        load_word("R8", pack4(15'o46100, 15'o46017, 15'o02345, 15'o55555));
        expect_slot("R8", 0, 1, pack4(15'o46100, 0, 0, 0), 1'b0);
        expect_slot("R8", 1, 1, pack4(15'o46017, 0, 0, 0), 1'b0);
        expect_slot("R8", 2, 2, pack4(15'o02345, 15'o55555, 0, 0), 1'b0);
        expect_idle("R8");
    endtask

    task automatic test_strict;
        ext_present = 1'b0; strict_mode = 1'b1;
        load_word("R9", pack4(15'o46000, 15'o46100, 15'o46017, 15'o36000));
        expect_slot("R5", 0, 1, pack4(15'o46000, 0, 0, 0), 1'b0);
        expect_slot("R9", 1, 1, pack4(15'o46100, 0, 0, 0), 1'b1);
        expect_slot("R9", 2, 1, pack4(15'o46017, 0, 0, 0), 1'b1);
        expect_slot("R9", 3, 1, pack4(15'o36000, 0, 0, 0), 1'b0);
        expect_idle("R9");
        // extension present and strict: y==0 variant faults, extension still legal
        ext_present = 1'b1;
        load_word("R9", pack4(15'o46300, 15'o12345, 15'o00000, 15'o00000));
        expect_slot("R9", 0, 4, pack4(15'o46300, 15'o12345, 0, 0), 1'b0);
        load_word("R9", pack4(15'o46017, 15'o10000, 15'o10000, 15'o10000));
        expect_slot("R9", 0, 1, pack4(15'o46017, 0, 0, 0), 1'b1);
        expect_slot("R9", 1, 1, pack4(15'o10000, 0, 0, 0), 1'b0);
        expect_slot("R9", 2, 1, pack4(15'o10000, 0, 0, 0), 1'b0);
        expect_slot("R9", 3, 1, pack4(15'o10000, 0, 0, 0), 1'b0);
        ext_present = 1'b0; strict_mode = 1'b0;
    endtask

    task automatic test_flush;
        load_word("R10", pack4(15'o10000, 15'o20000, 15'o30000, 15'o40000));
        expect_slot("R10", 0, 1, pack4(15'o10000, 0, 0, 0), 1'b0);
        flush = 1'b1;
        #1;
        chk("R10", "issue_valid in flush", 64'(issue_valid), 64'd0);
        chk("R10", "fetch_req in flush", 64'(fetch_req), 64'd0);
        @(negedge clk);
        flush = 1'b0;
        expect_idle("R10");
        load_word("R10", pack4(15'o21000, 15'o22000, 15'o23000, 15'o24000));
        expect_slot("R10", 0, 1, pack4(15'o21000, 0, 0, 0), 1'b0);
        expect_slot("R10", 1, 1, pack4(15'o22000, 0, 0, 0), 1'b0);
        expect_slot("R10", 2, 1, pack4(15'o23000, 0, 0, 0), 1'b0);
        expect_slot("R10", 3, 1, pack4(15'o24000, 0, 0, 0), 1'b0);
    endtask

    task automatic test_stall;
        for (int i = 0; i < 4; i++) expect_idle("R4");
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_short_words();
        test_long_words();
        test_straddle();
        test_extension();
        test_no_extension();
        test_strict();
        test_flush();
        test_stall();
        finish_run();
    end
endmodule